// File: doc/BRIEF.md
# Block-Transfer DMA Command Controller

This block is the command side of a DMA engine. It moves whole blocks of a fixed, power-of-two size between a local block store and the byte address space of a host bus. Software programs three values through a small register file: a starting local block number, a starting host byte address, and a block count whose top bit gives the direction. Writing a nonzero count starts the engine.

For each block the engine raises one burst request toward a bus-master port. The request carries the current block number, host address and direction, and it is held until the port acknowledges it. On each acknowledge the block number steps by one, the host address steps by the block size in bytes, and the remaining count drops by one. The count register reads back the live remaining count, so software polls it together with a status word. Both reach zero when the engine is ready again.

Three read-only registers describe the geometry: the block size, the block base, and the store size in blocks. Software uses them to turn byte offsets into block numbers. The host bus is big-endian, so every register word is byte-reversed as it crosses the register port, in both directions.

Top module: `blk_dma_ctrl`

## Requirements
- R1: After reset the count register reads 0, the status register reads 0 and `req_valid` is low.
- R2: Byte offset 0x00 reads the block size in bytes (default 512), 0x04 reads the block base (default 0x80) and 0x08 reads the store size in blocks (default 1024). Writes to these offsets have no effect.
- R3: Register data is byte-reversed at the port in both directions. Bus bits 7:0 map to internal bits 31:24, bus bits 15:8 to internal 23:16, bus bits 23:16 to internal 15:8, and bus bits 31:24 to internal 7:0.
- R4: Offset 0x10 holds the local block number, 0x14 holds the host byte address and 0x18 is the count register. While idle, a write to 0x18 whose internal bits 30:0 are nonzero starts a transfer of that many blocks. A write whose bits 30:0 are zero starts nothing and leaves the status unchanged.
- R5: Internal bit 31 of the count write sets `req_dir`. A 1 moves data from the local store to the host, and a 0 moves data from the host into the local store.
- R6: The engine issues exactly one request per block, in order. `req_blk` and `req_host` give the block's addresses, and the request stays asserted with stable fields until `req_ack`.
- R7: After each acknowledged request the block number rises by 1 and the host address rises by the block size. Both are readable at 0x10 and 0x14.
- R8: Reading the count register returns the number of blocks not yet acknowledged, with bit 31 reading 0. It reads 0 once the engine is idle.
- R9: The status register at 0x2C uses internal bits 4:0. Bit 0 is busy and is 1 from the start command until the engine returns to idle. Bits 4:3 read 0.
- R10: While busy, writes to 0x10, 0x14 and 0x18 are ignored. A write to 0x18 also sets status bit 1.
- R11: If the block number is not below the store size when a request would be issued, status bit 2 is set, no request is issued, the count drops to 0 and the engine goes idle.
- R12: Status bits 1 and 2 stay set until the next valid start command, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset |
| csr_wdata | input | 32 | Register write data, host byte order |
| csr_rdata | output | 32 | Register read data, host byte order |
| req_valid | output | 1 | Block burst request |
| req_dir | output | 1 | 1 = local store to host, 0 = host to local store |
| req_blk | output | 32 | Local block number of the request |
| req_host | output | 32 | Host byte address of the request |
| req_ack | input | 1 | Burst completed for the current request |

## Verification
The bench targets the range check at the exact edge of the store. It runs a transfer whose last legal block is the final block of the store, and one that would step past it. A design with an off-by-one compare would either issue a request beyond the store or refuse a legal block. A second command is written in the middle of a transfer. A design that accepted it would restart the countdown or flip the direction, and the bench sees this in the count readback and in `req_dir`. A zero-count write and a write to the geometry registers are both followed by readbacks, to catch a design that starts on an empty count or lets software alter the geometry. Finally, a raw, unswapped bus word is written and then compared against the request fields, which exposes a byte map that is mirrored the wrong way.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

    // register byte offsets on the host bus
    localparam logic [5:0] OFF_GEO_SIZE = 6'h00;
    localparam logic [5:0] OFF_GEO_BASE = 6'h04;
    localparam logic [5:0] OFF_GEO_MEM  = 6'h08;
    localparam logic [5:0] OFF_BLK      = 6'h10;
    localparam logic [5:0] OFF_HOST     = 6'h14;
    localparam logic [5:0] OFF_COUNT    = 6'h18;
    localparam logic [5:0] OFF_STATUS   = 6'h2C;

    // count register layout
    localparam int CNT_W   = 31;
    localparam int DIR_BIT = 31;

    // status flag positions
    localparam int ST_BUSY    = 0;
    localparam int ST_OVERLAP = 1;
    localparam int ST_RANGE   = 2;
    localparam int ST_W       = 5;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_CHECK,
        SEQ_REQ
    } seq_state_e;

    typedef struct packed {
        logic blk;
        logic host;
        logic cnt;
    } wr_strobe_t;

    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/blk_dma_regs.sv
module blk_dma_regs
    import blk_dma_pkg::*;
#(
    parameter int BLK_BYTES  = 512,
    parameter int BLK_BASE   = 32'h80,
    parameter int MEM_BLOCKS = 1024
) (
    input  logic             csr_we,
    input  logic [5:0]       csr_addr,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    output wr_strobe_t       wr,
    output logic [31:0]      wdata_int,
    input  logic [31:0]      blk_q,
    input  logic [31:0]      host_q,
    input  logic [CNT_W-1:0] remain_q,
    input  logic [ST_W-1:0]  status_q
);

    localparam logic [31:0] GEO_SIZE = 32'(BLK_BYTES);
    localparam logic [31:0] GEO_BASE = 32'(BLK_BASE);
    localparam logic [31:0] GEO_MEM  = 32'(MEM_BLOCKS);

    logic [31:0] rd_int;

    assign wdata_int = bswap32(csr_wdata);

    always_comb begin
        wr.blk  = csr_we && (csr_addr == OFF_BLK);
        wr.host = csr_we && (csr_addr == OFF_HOST);
        wr.cnt  = csr_we && (csr_addr == OFF_COUNT);
    end

    always_comb begin
        case (csr_addr)
            OFF_GEO_SIZE: rd_int = GEO_SIZE;
            OFF_GEO_BASE: rd_int = GEO_BASE;
            OFF_GEO_MEM:  rd_int = GEO_MEM;
            OFF_BLK:      rd_int = blk_q;
            OFF_HOST:     rd_int = host_q;
            OFF_COUNT:    rd_int = {1'b0, remain_q};
            OFF_STATUS:   rd_int = {{(32-ST_W){1'b0}}, status_q};
            default:      rd_int = 32'h0;
        endcase
    end

    assign csr_rdata = bswap32(rd_int);

    always_comb begin
        AST_ONE_STROBE: assert ($countones({wr.blk, wr.host, wr.cnt}) <= 1); // R4
    end

endmodule

// File: rtl/blk_dma_seq.sv
module blk_dma_seq
    import blk_dma_pkg::*;
#(
    parameter int BLK_BYTES  = 512,
    parameter int MEM_BLOCKS = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strobe_t       wr,
    input  logic [31:0]      wdata_int,
    output logic [31:0]      blk_q,
    output logic [31:0]      host_q,
    output logic [CNT_W-1:0] remain_q,
    output logic [ST_W-1:0]  status_q,
    output logic             req_valid,
    output logic             req_dir,
    input  logic             req_ack
);

    localparam logic [31:0] MEM_LIMIT = 32'(MEM_BLOCKS);
    localparam logic [31:0] STEP      = 32'(BLK_BYTES);

    seq_state_e       state;
    logic             dir_q;
    logic             err_overlap_q;
    logic             err_range_q;
    logic [CNT_W-1:0] cnt_field;
    logic             start_cmd;

    assign cnt_field = wdata_int[CNT_W-1:0];
    assign start_cmd = wr.cnt && (cnt_field != '0) && (state == SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= SEQ_IDLE;
            blk_q         <= '0;
            host_q        <= '0;
            remain_q      <= '0;
            dir_q         <= 1'b0;
            err_overlap_q <= 1'b0;
            err_range_q   <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (wr.blk)  blk_q  <= wdata_int;
                    if (wr.host) host_q <= wdata_int;
                    if (start_cmd) begin
                        remain_q      <= cnt_field;
                        dir_q         <= wdata_int[DIR_BIT];
                        err_overlap_q <= 1'b0;
                        err_range_q   <= 1'b0;
                        state         <= SEQ_CHECK;
                    end
                end
                SEQ_CHECK: begin
                    if (blk_q >= MEM_LIMIT) begin
                        err_range_q <= 1'b1;
                        remain_q    <= '0;
                        state       <= SEQ_IDLE;
                    end else begin
                        state <= SEQ_REQ;
                    end
                end
                SEQ_REQ: begin
                    if (req_ack) begin
                        blk_q    <= blk_q + 32'd1;
                        host_q   <= host_q + STEP;
                        remain_q <= remain_q - 1'b1;
                        state    <= (remain_q == CNT_W'(1)) ? SEQ_IDLE : SEQ_CHECK;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
            if (state != SEQ_IDLE && wr.cnt) err_overlap_q <= 1'b1;
        end
    end

    assign req_valid = (state == SEQ_REQ);
    assign req_dir   = dir_q;
    assign status_q  = {2'b00, err_range_q, err_overlap_q, state != SEQ_IDLE};

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ack |=> req_valid && $stable(blk_q) && $stable(host_q)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ack |=> blk_q == $past(blk_q) + 32'd1 && host_q == $past(host_q) + STEP); // R7
    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ack |=> remain_q == CNT_W'($past(remain_q) - 1'b1)); // R8
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !status_q[ST_BUSY] |-> remain_q == '0); // R8
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> blk_q < MEM_LIMIT); // R11
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        status_q[ST_BUSY] && wr.cnt |=> $stable(dir_q) && err_overlap_q); // R10

endmodule

// File: rtl/blk_dma_ctrl.sv
module blk_dma_ctrl
    import blk_dma_pkg::*;
#(
    parameter int BLK_BYTES  = 512,
    parameter int BLK_BASE   = 32'h80,
    parameter int MEM_BLOCKS = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_we,
    input  logic [5:0]  csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        req_valid,
    output logic        req_dir,
    output logic [31:0] req_blk,
    output logic [31:0] req_host,
    input  logic        req_ack
);

    wr_strobe_t       wr;
    logic [31:0]      wdata_int;
    logic [31:0]      blk_q;
    logic [31:0]      host_q;
    logic [CNT_W-1:0] remain_q;
    logic [ST_W-1:0]  status_q;

    blk_dma_regs #(
        .BLK_BYTES (BLK_BYTES),
        .BLK_BASE  (BLK_BASE),
        .MEM_BLOCKS(MEM_BLOCKS)
    ) u_regs (
        .csr_we   (csr_we),
        .csr_addr (csr_addr),
        .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .wr       (wr),
        .wdata_int(wdata_int),
        .blk_q    (blk_q),
        .host_q   (host_q),
        .remain_q (remain_q),
        .status_q (status_q)
    );

    blk_dma_seq #(
        .BLK_BYTES (BLK_BYTES),
        .MEM_BLOCKS(MEM_BLOCKS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .wdata_int(wdata_int),
        .blk_q    (blk_q),
        .host_q   (host_q),
        .remain_q (remain_q),
        .status_q (status_q),
        .req_valid(req_valid),
        .req_dir  (req_dir),
        .req_ack  (req_ack)
    );

    assign req_blk  = blk_q;
    assign req_host = host_q;

endmodule

// File: tb/blk_dma_ctrl_tb.sv
`timescale 1ns/1ps
module blk_dma_ctrl_tb;

    localparam int BB   = 512;
    localparam int BASE = 32'h80;
    localparam int MEMB = 1024;

    typedef struct packed {
        logic [31:0] blk;
        logic [31:0] host;
        logic [15:0] cnt;
        logic        dir;
    } xfer_t;

    localparam xfer_t VEC [0:3] = '{
        '{32'h10,  32'h0000_1000, 16'd3, 1'b1},
        '{32'h20,  32'h0008_0000, 16'd1, 1'b0},
        '{32'd1022, 32'h0,        16'd2, 1'b1},
        '{32'h0,   32'hFFFF_FC00, 16'd2, 1'b0}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        csr_we = 0;
    logic [5:0]  csr_addr = 0;
    logic [31:0] csr_wdata = 0;
    logic [31:0] csr_rdata;
    logic        req_valid, req_dir, req_ack = 0;
    logic [31:0] req_blk, req_host;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    blk_dma_ctrl u_dut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
        .req_dir(req_dir), .req_blk(req_blk), .req_host(req_host), .req_ack(req_ack)
    );

    function automatic logic [31:0] sw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [5:0] off, input logic [31:0] bus);
        csr_we = 1; csr_addr = off; csr_wdata = bus;
        @(negedge clk);
        csr_we = 0;
    endtask

    task automatic wr(input logic [5:0] off, input logic [31:0] val);
        wr_raw(off, sw(val));
    endtask

    task automatic rd(input logic [5:0] off, output logic [31:0] val);
        csr_addr = off;
        #1;
        val = sw(csr_rdata);
    endtask

    task automatic wait_req();
        for (int n = 0; n < 8 && !req_valid; n++) @(negedge clk);
    endtask

    task automatic ack_once();
        req_ack = 1;
        @(negedge clk);
        req_ack = 0;
    endtask

    // runs a clean transfer and checks every request and readback
    task automatic run_xfer(input logic [31:0] blk, input logic [31:0] host,
                            input int cnt, input logic dir, input bit raw_host);
        logic [31:0] v;
        wr(6'h10, blk);
        if (raw_host) wr_raw(6'h14, sw(host)); else wr(6'h14, host);
        wr(6'h18, {dir, 31'(cnt)});
        for (int i = 0; i < cnt; i++) begin
            wait_req();
            chk("R6 req_valid", 32'(req_valid), 32'd1);
            chk("R6 req_blk", req_blk, blk + 32'(i));
            chk("R7 req_host", req_host, host + 32'(i * BB));
            chk("R5 req_dir", 32'(req_dir), 32'(dir));
            rd(6'h18, v); chk("R8 remaining", v, 32'(cnt - i));
            rd(6'h2C, v); chk("R9 R12 status busy", v, 32'd1);
            ack_once();
        end
        @(negedge clk);
        chk("R6 no extra req", 32'(req_valid), 32'd0);
        rd(6'h18, v); chk("R8 count idle", v, 32'd0);
        rd(6'h2C, v); chk("R9 status idle", v, 32'd0);
        rd(6'h10, v); chk("R7 blk final", v, blk + 32'(cnt));
        rd(6'h14, v); chk("R7 host final", v, host + 32'(cnt * BB));
    endtask

    initial begin : watchdog
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(6'h18, v); chk("R1 count", v, 32'd0);
        rd(6'h2C, v); chk("R1 status", v, 32'd0);
        chk("R1 req_valid", 32'(req_valid), 32'd0);

        // R2 / R3 geometry and byte order
        csr_addr = 6'h00; #1; chk("R3 raw size bytes", csr_rdata, 32'h0002_0000);
        rd(6'h00, v); chk("R2 block size", v, 32'(BB));
        rd(6'h04, v); chk("R2 block base", v, 32'(BASE));
        rd(6'h08, v); chk("R2 mem size", v, 32'(MEMB));
        wr(6'h00, 32'hDEAD_BEEF);
        wr(6'h08, 32'h0000_0001);
        rd(6'h00, v); chk("R2 size after write", v, 32'(BB));
        rd(6'h08, v); chk("R2 mem after write", v, 32'(MEMB));

        // table walk
        for (int k = 0; k < 4; k++)
            run_xfer(VEC[k].blk, VEC[k].host, int'(VEC[k].cnt), VEC[k].dir, 1'b0);

        // R4 zero count starts nothing
        wr(6'h18, 32'h8000_0000);
        for (int k = 0; k < 3; k++) begin
            chk("R4 zero count no req", 32'(req_valid), 32'd0);
            @(negedge clk);
        end
        rd(6'h2C, v); chk("R4 zero count status", v, 32'd0);

        // R10 writes while busy
        wr(6'h10, 32'd5);
        wr(6'h14, 32'h2000);
        wr(6'h18, 32'h8000_0002);
        wait_req();
        wr(6'h18, 32'h0000_0009);
        wr(6'h10, 32'h77);
        rd(6'h2C, v); chk("R10 overlap flag", v, 32'd3);
        rd(6'h18, v); chk("R10 count kept", v, 32'd2);
        chk("R10 dir kept", 32'(req_dir), 32'd1);
        chk("R10 blk kept", req_blk, 32'd5);
        ack_once();
        wait_req();
        chk("R10 second blk", req_blk, 32'd6);
        ack_once();
        @(negedge clk);
        rd(6'h2C, v); chk("R12 overlap sticky", v, 32'd2);
        rd(6'h10, v); chk("R10 blk after", v, 32'd7);

        // R11 start past the store
        wr(6'h10, 32'(MEMB));
        wr(6'h18, 32'h0000_0001);
        for (int k = 0; k < 3; k++) begin
            chk("R11 no req out of range", 32'(req_valid), 32'd0);
            @(negedge clk);
        end
        rd(6'h2C, v); chk("R11 R12 range flag", v, 32'd4);
        rd(6'h18, v); chk("R11 count cleared", v, 32'd0);

        // R11 stepping past the last block
        wr(6'h10, 32'(MEMB - 1));
        wr(6'h18, 32'h0000_0003);
        wait_req();
        chk("R11 last legal blk", req_blk, 32'(MEMB - 1));
        ack_once();
        for (int k = 0; k < 3; k++) begin
            chk("R11 stop at edge", 32'(req_valid), 32'd0);
            @(negedge clk);
        end
        rd(6'h2C, v); chk("R11 range flag edge", v, 32'd4);
        rd(6'h18, v); chk("R11 count zero edge", v, 32'd0);
        rd(6'h10, v); chk("R11 blk at edge", v, 32'(MEMB));

        // R12 recovery and R3 raw host word
        run_xfer(32'd40, 32'h1234_5678, 2, 1'b0, 1'b1);
        wr_raw(6'h14, 32'h7856_3412);
        csr_addr = 6'h14; #1; chk("R3 raw readback", csr_rdata, 32'h7856_3412);
        rd(6'h14, v); chk("R3 internal map", v, 32'h1234_5678);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule